// File: doc/BRIEF.md
# Megabyte-Granular Cartridge ROM Bank Mapper

This block turns a 24-bit CPU bus address into a 23-bit address for a cartridge ROM of up to 8 MB. The ROM is treated as eight images of 1 MB each. Four mapping slots decide which image is visible in each window. Every slot feeds two windows. The first is a linear window of sixteen 64 KB banks in the upper quarter of the bus. The second is a half-bank window of thirty-two banks, where only the upper 32 KB of each bank is decoded. A per-slot projection flag decides what the half-bank window shows. With the flag set, it follows the slot's image. With the flag clear, it stays on a fixed image equal to the slot's index.

The slots are written through a small configuration port made of an address, a data byte, a strobe and a side-select bit. Only writes from the main processor side are accepted. The lookup port is purely combinational and is shared by every ROM requester: the main CPU, the coprocessor, the DMA engine and the variable-length bit reader. All of them therefore see the same translation.

Top module: `rom_image_mapper`

## Requirements
- R1: After a synchronous active-low reset the slots hold image 0, 1, 2, 3 in slot order (C, D, E, F), with every projection flag clear.
- R2: A strobed write from the main side (`cfg_from_cop`=0) to address $2220+k (k = 0..3 for C, D, E, F) loads slot k. Data bit 7 becomes the projection flag and bits 2..0 become the image number. Bits 6..3 are discarded.
- R3: A strobed write with `cfg_from_cop`=1 leaves every slot unchanged.
- R4: A strobed write to any address other than $2220..$2223 leaves every slot unchanged.
- R5: Banks $C0-$FF form the linear window. Slot index = bank[5:4]. `rom_sel`=1 and `rom_addr` = {image, bank[3:0], addr[15:0]}.
- R6: Banks $00-$3F and $80-$BF at offsets $8000-$FFFF form the half-bank window. Slot index = {bank[7], bank[5]}, so C covers $00-$1F, D $20-$3F, E $80-$9F and F $A0-$BF. `rom_sel`=1 and `rom_addr` = {image, bank[4:0], addr[14:0]}.
- R7: In the half-bank window the image is the slot's image when its flag is set, and the slot index when its flag is clear.
- R8: Banks $40-$7F, and offsets below $8000 in the half-bank ranges, give `rom_sel`=0 and `rom_addr`=0.
- R9: A write takes effect on the clock edge that samples the strobe. A lookup made before that edge still uses the old mapping. A lookup made after it uses the new one.
- R10: Writing $04, $05, $06, $07 exposes the first 4 MB in the half-bank windows and images 4..7 in the linear windows.
- R11: Writing $80, $81, $80, $81 gives a 2 MB half-bank layout. Banks $00-$3F and $80-$BF then return identical ROM addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_from_cop | input | 1 | 1 = write comes from the coprocessor side |
| cfg_addr | input | 16 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| lk_addr | input | 24 | CPU bus address to translate |
| rom_sel | output | 1 | Address falls inside a ROM window |
| rom_addr | output | 23 | Translated ROM byte address |

## Verification
The assertions assume that `cfg_we`, `cfg_addr`, `cfg_wdata` and `cfg_from_cop` are stable and known at every sampling edge. They also assume that `lk_addr` holds no X, since the window and address checks read it directly. The bench changes all inputs only on the falling clock edge. It raises the strobe for exactly one cycle per write and holds a known lookup address at all times. Reset is held for several edges before the first write.

// File: rtl/rom_map_pkg.sv
// Package: shared types for the ROM image mapper.
// Assumes four mapping slots and eight 1 MB images (3-bit image number).
package rom_map_pkg;
    localparam int IMG_W     = 3;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    // One mapping slot: projection flag plus image number.
    typedef struct packed {
        logic             proj;
        logic [IMG_W-1:0] img;
    } slot_t;

    // Which window a lookup address hits.
    typedef enum logic [1:0] {
        WIN_NONE   = 2'd0,
        WIN_LINEAR = 2'd1,
        WIN_HALF   = 2'd2
    } win_e;
endpackage

// File: rtl/rom_map_regs.sv
// Module: slot register file.
// Holds the four mapping slots. It accepts only main-side writes whose
// address falls within CFG_BASE .. CFG_BASE+NUM_SLOTS-1.
// Assumes the strobe is a single-cycle pulse sampled on the rising edge.
module rom_map_regs
    import rom_map_pkg::*;
#(
    parameter int              CFG_AW   = 16,
    parameter logic [CFG_AW-1:0] CFG_BASE = 16'h2220
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic                         cfg_from_cop,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [7:0]                   cfg_wdata,
    output slot_t [NUM_SLOTS-1:0]        slots_q
);
    logic [CFG_AW-1:0] cfg_off;
    logic              cfg_hit;
    logic              cfg_ok;
    logic [SLOT_W-1:0] cfg_idx;
    slot_t             wr_val;
    logic              unused_wdata;

    // Offset from the register base; unsigned wrap rejects addresses below it.
    always_comb begin
        cfg_off = cfg_addr - CFG_BASE;
        cfg_hit = (cfg_off < CFG_AW'(NUM_SLOTS));
        cfg_idx = cfg_off[SLOT_W-1:0];
        cfg_ok  = cfg_we && !cfg_from_cop && cfg_hit;
    end

    // Keep only the flag bit and the image field of the write data.
    always_comb begin
        wr_val.proj  = cfg_wdata[7];
        wr_val.img   = cfg_wdata[IMG_W-1:0];
        unused_wdata = ^cfg_wdata[6:IMG_W];
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // Slot g: load its default on reset, or take an accepted write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots_q[g].proj <= 1'b0;
                slots_q[g].img  <= IMG_W'(g);
            end else if (cfg_ok && (cfg_idx == SLOT_W'(g))) begin
                slots_q[g] <= wr_val;
            end
        end
    end
endmodule

// File: rtl/rom_map_decode.sv
// Module: window classifier.
// Works out from the bank byte and bit 15 which window a bus address
// falls in, and which slot governs it.
// Assumes a 24-bit bus whose bank number is the top byte.
module rom_map_decode
    import rom_map_pkg::*;
#(
    parameter int CPU_AW = 24
) (
    input  logic [CPU_AW-1:0] lk_addr,
    output win_e              win,
    output logic [SLOT_W-1:0] slot_idx
);
    localparam int BANK_LO = CPU_AW - 8;

    logic [7:0] bank;
    logic       hi_half;

    // Split the address into its bank byte and its upper-half flag.
    always_comb begin
        bank    = lk_addr[CPU_AW-1:BANK_LO];
        hi_half = lk_addr[15];
    end

    // Classify the window and pick the governing slot.
    always_comb begin
        win      = WIN_NONE;
        slot_idx = '0;
        if (bank[7:6] == 2'b11) begin
            win      = WIN_LINEAR;
            slot_idx = bank[5:4];
        end else if (!bank[6]) begin
            slot_idx = {bank[7], bank[5]};
            if (hi_half) begin
                win = WIN_HALF;
            end
        end
    end
endmodule

// File: rtl/rom_map_form.sv
// Module: ROM address former.
// Builds the ROM address from the window class, the governing slot and the
// low address bits. Outside every window it drives zero and deselects.
// Assumes the slot index comes from rom_map_decode for the same address.
module rom_map_form
    import rom_map_pkg::*;
#(
    parameter int ROM_AW = IMG_W + 20
) (
    input  win_e                  win,
    input  logic [SLOT_W-1:0]     slot_idx,
    input  slot_t [NUM_SLOTS-1:0] slots,
    input  logic [20:0]           low_addr,
    output logic                  rom_sel,
    output logic [ROM_AW-1:0]     rom_addr
);
    slot_t            cur;
    logic [IMG_W-1:0] half_img;

    // Fetch the governing slot and choose the image the half-bank window shows.
    always_comb begin
        cur      = slots[slot_idx];
        half_img = cur.proj ? cur.img : IMG_W'(slot_idx);
    end

    // Put the ROM address together for the window that was hit.
    always_comb begin
        rom_sel  = 1'b0;
        rom_addr = '0;
        case (win)
            WIN_LINEAR: begin
                rom_sel  = 1'b1;
                rom_addr = {cur.img, low_addr[19:16], low_addr[15:0]};
            end
            WIN_HALF: begin
                rom_sel  = 1'b1;
                rom_addr = {half_img, low_addr[20:16], low_addr[14:0]};
            end
            default: begin
                rom_sel  = 1'b0;
                rom_addr = '0;
            end
        endcase
    end
endmodule

// File: rtl/rom_image_mapper.sv
// Module: top of the cartridge ROM image mapper.
// Joins the slot register file, the window classifier and the address
// former. Lookup is combinational from the current slot contents.
// Assumes a single clock domain for the configuration port.
module rom_image_mapper
    import rom_map_pkg::*;
#(
    parameter int                CFG_AW   = 16,
    parameter logic [CFG_AW-1:0] CFG_BASE = 16'h2220,
    parameter int                CPU_AW   = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic                    cfg_from_cop,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [7:0]              cfg_wdata,
    input  logic [CPU_AW-1:0]       lk_addr,
    output logic                    rom_sel,
    output logic [IMG_W+19:0]       rom_addr
);
    localparam int ROM_AW = IMG_W + 20;

    slot_t [NUM_SLOTS-1:0] slots_q;
    win_e                  win;
    logic [SLOT_W-1:0]     slot_idx;

    rom_map_regs #(.CFG_AW(CFG_AW), .CFG_BASE(CFG_BASE)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_from_cop (cfg_from_cop),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .slots_q      (slots_q)
    );

    rom_map_decode #(.CPU_AW(CPU_AW)) u_decode (
        .lk_addr  (lk_addr),
        .win      (win),
        .slot_idx (slot_idx)
    );

    rom_map_form #(.ROM_AW(ROM_AW)) u_form (
        .win      (win),
        .slot_idx (slot_idx),
        .slots    (slots_q),
        .low_addr (lk_addr[20:0]),
        .rom_sel  (rom_sel),
        .rom_addr (rom_addr)
    );
endmodule

// File: rtl/rom_map_checker.sv
// Module: assertion checker bound to rom_image_mapper.
// Assumes inputs are known at every rising edge.
module rom_map_checker
    import rom_map_pkg::*;
#(
    parameter int                CFG_AW   = 16,
    parameter logic [CFG_AW-1:0] CFG_BASE = 16'h2220,
    parameter int                CPU_AW   = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_we,
    input logic                  cfg_from_cop,
    input logic [CFG_AW-1:0]     cfg_addr,
    input logic [7:0]            cfg_wdata,
    input logic [CPU_AW-1:0]     lk_addr,
    input logic                  rom_sel,
    input logic [IMG_W+19:0]     rom_addr,
    input slot_t [NUM_SLOTS-1:0] slots_q
);
    logic out_of_range;
    always_comb out_of_range = (cfg_addr < CFG_BASE) ||
                               (cfg_addr >= CFG_BASE + CFG_AW'(NUM_SLOTS));

    assert_reset_defaults_R1: assert property (@(posedge clk)
        !rst_n |=> (slots_q[0] == 4'h0 && slots_q[1] == 4'h1 &&
                    slots_q[2] == 4'h2 && slots_q[3] == 4'h3));

    assert_slot_c_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_from_cop && cfg_addr == CFG_BASE) |=>
        (slots_q[0] == {$past(cfg_wdata[7]), $past(cfg_wdata[IMG_W-1:0])}));

    assert_cop_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_from_cop) |=> $stable(slots_q));

    assert_range_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && out_of_range) |=> $stable(slots_q));

    assert_linear_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_addr[CPU_AW-1:CPU_AW-2] == 2'b11) |->
        (rom_sel && rom_addr[19:0] == lk_addr[19:0]));

    assert_half_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_addr[CPU_AW-2] && lk_addr[15]) |->
        (rom_sel && rom_addr[19:0] == {lk_addr[20:16], lk_addr[14:0]}));

    assert_outside_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_sel |-> (rom_addr == '0));

    assert_outside_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_addr[CPU_AW-1:CPU_AW-2] == 2'b01) |-> !rom_sel);
endmodule

bind rom_image_mapper rom_map_checker #(
    .CFG_AW(CFG_AW), .CFG_BASE(CFG_BASE), .CPU_AW(CPU_AW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_from_cop (cfg_from_cop),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .lk_addr      (lk_addr),
    .rom_sel      (rom_sel),
    .rom_addr     (rom_addr),
    .slots_q      (slots_q)
);

// File: tb/tb_rom_image_mapper.sv
// Directed bench for rom_image_mapper: one task per scenario.
module tb_rom_image_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_from_cop = 1'b0;
    logic [15:0] cfg_addr = 16'h0000;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [23:0] lk_addr = 24'h000000;
    logic        rom_sel;
    logic [22:0] rom_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench shadow of the slot state, built from the requirements.
    logic [2:0] sh_img [4];
    logic       sh_flag[4];

    always #4 clk = ~clk;

    rom_image_mapper dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_from_cop(cfg_from_cop),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .lk_addr(lk_addr),
        .rom_sel(rom_sel), .rom_addr(rom_addr)
    );

    function automatic logic [23:0] model(input logic [23:0] a);
        logic [7:0] b;
        int         k;
        logic [2:0] im;
        b = a[23:16];
        if (b[7:6] == 2'b11) begin
            k = int'(b[5:4]);
            return {1'b1, sh_img[k], b[3:0], a[15:0]};
        end else if (!b[6] && a[15]) begin
            k  = int'({b[7], b[5]});
            im = sh_flag[k] ? sh_img[k] : 3'(k);
            return {1'b1, im, b[4:0], a[14:0]};
        end
        return 24'h0;
    endfunction

    task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic look(input string tag, input logic [23:0] a);
        @(negedge clk);
        lk_addr = a;
        #1;
        chk(tag, {rom_sel, rom_addr}, model(a));
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic cop);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_from_cop = cop;
        @(negedge clk);
        cfg_we = 1'b0; cfg_from_cop = 1'b0;
        if (!cop && a >= 16'h2220 && a <= 16'h2223) begin
            sh_img[a - 16'h2220]  = d[2:0];
            sh_flag[a - 16'h2220] = d[7];
        end
    endtask

    task automatic t_reset;
        for (int k = 0; k < 4; k++) begin sh_img[k] = 3'(k); sh_flag[k] = 1'b0; end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        look("R1 C linear", 24'hC01234);
        chk("R1 C image0", {rom_sel, rom_addr}, 24'h801234);
        look("R1 F linear", 24'hF5ABCD);
        chk("R1 F image3", {rom_sel, rom_addr}, {1'b1, 23'h35ABCD});
        look("R1 E half", 24'h81C000);
        chk("R1 E half fixed", {rom_sel, rom_addr}, {1'b1, 3'd2, 5'h01, 15'h4000});
    endtask

    task automatic t_write_fields;
        wr(16'h2221, 8'h7D, 1'b0);
        look("R2 D bits6..3 dropped", 24'hD00010);
        chk("R2 D image5", {rom_sel, rom_addr}, {1'b1, 3'd5, 4'h0, 16'h0010});
        wr(16'h2221, 8'hFE, 1'b0);
        look("R2 R7 D projected", 24'h3F8001);
        chk("R7 D flag set image6", {rom_sel, rom_addr}, {1'b1, 3'd6, 5'h1F, 15'h0001});
    endtask

    task automatic t_ignored;
        wr(16'h2220, 8'h87, 1'b1);
        look("R3 cop write linear", 24'hC70000);
        chk("R3 C unchanged", {rom_sel, rom_addr}, {1'b1, 3'd0, 4'h7, 16'h0000});
        look("R3 cop write half", 24'h008000);
        wr(16'h2224, 8'h87, 1'b0);
        wr(16'h221F, 8'h87, 1'b0);
        look("R4 out-of-range C", 24'hC00000);
        look("R4 out-of-range F", 24'hF00000);
        chk("R4 F unchanged", {rom_sel, rom_addr}, {1'b1, 3'd3, 20'h0});
    endtask

    task automatic t_windows;
        look("R8 bank 40", 24'h40FFFF);
        look("R8 bank 7F", 24'h7F8000);
        look("R8 low half", 24'h207FFF);
        chk("R8 low half zero", {rom_sel, rom_addr}, 24'h0);
        look("R6 bank BF", 24'hBFFFFF);
        look("R6 bank A0", 24'hA08000);
        look("R5 bank E9", 24'hE90042);
    endtask

    task automatic t_timing;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 16'h2223; cfg_wdata = 8'h86; cfg_from_cop = 1'b0;
        lk_addr = 24'hF00000;
        #1;
        chk("R9 before edge", {rom_sel, rom_addr}, {1'b1, 3'd3, 20'h0});
        @(negedge clk);
        cfg_we = 1'b0;
        sh_img[3] = 3'd6; sh_flag[3] = 1'b1;
        #1;
        chk("R9 after edge", {rom_sel, rom_addr}, {1'b1, 3'd6, 20'h0});
    endtask

    task automatic t_layouts;
        wr(16'h2220, 8'h04, 1'b0); wr(16'h2221, 8'h05, 1'b0);
        wr(16'h2222, 8'h06, 1'b0); wr(16'h2223, 8'h07, 1'b0);
        look("R10 C0", 24'hC00000);
        chk("R10 C0 image4", {rom_sel, rom_addr}, {1'b1, 23'h400000});
        look("R10 FF", 24'hFFFFFF);
        chk("R10 FF top", {rom_sel, rom_addr}, {1'b1, 23'h7FFFFF});
        look("R10 bank00", 24'h008000);
        chk("R10 bank00 image0", {rom_sel, rom_addr}, {1'b1, 23'h000000});
        look("R10 bankBF", 24'hBFFFFF);
        chk("R10 bankBF image3", {rom_sel, rom_addr}, {1'b1, 23'h3FFFFF});
        wr(16'h2220, 8'h80, 1'b0); wr(16'h2221, 8'h81, 1'b0);
        wr(16'h2222, 8'h80, 1'b0); wr(16'h2223, 8'h81, 1'b0);
        for (int b = 0; b < 64; b += 7) begin
            logic [23:0] lo;
            logic [23:0] hi;
            look("R11 low half bank", {8'(b), 16'h9ABC});
            lo = {rom_sel, rom_addr};
            look("R11 high half bank", {8'(b + 128), 16'h9ABC});
            hi = {rom_sel, rom_addr};
            chk("R11 mirror", hi, lo);
        end
        look("R11 bank3F end", 24'h3FFFFF);
        chk("R11 2MB top", {rom_sel, rom_addr}, {1'b1, 23'h1FFFFF});
    endtask

    initial begin
        t_reset();
        t_write_fields();
        t_ignored();
        t_windows();
        t_timing();
        t_layouts();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule